// File: doc/BRIEF.md
# Two-Channel Pulse-Width Generator

This block drives two independent pulse-width outputs. Software reaches it through a small register port: an address, write data, a write strobe and a combinational read-data path. Each channel has a 32-bit word that packs a high-phase count and a low-phase count. A shared control word sets, for each channel, a run bit, a tick gate, a 7-bit prescaler and a selector that picks one of four tick sources.

The tick sources are single-cycle strobes in the block's clock domain, so no real clock switching is involved. A channel takes its selected strobe and passes it through its gate. It divides the result by the prescaler value plus one. Each divided tick is one step of the waveform. A channel drives high for its high count of steps and then low for its low count of steps, and repeats. A word written while a channel runs waits until the current period ends before it takes effect.

Top module: `duo_pwm`

## Requirements
- R1: The register map is: offset 0x0 holds the channel 0 word, 0x4 the channel 1 word, 0x8 the control word. Each reads back the last value written. Control bits 2, 3 and 24..31 read as zero. Any other offset reads zero.
- R2: In a channel word, bits [31:16] are the high-phase count and bits [15:0] the low-phase count.
- R3: Control bit 0 runs channel 0 and bit 1 runs channel 1. The two channels operate independently.
- R4: Control bits [5:4] (channel 0) and [7:6] (channel 1) select which bit of `tick_src` feeds the channel.
- R5: Control bits [14:8] (channel 0) and [22:16] (channel 1) hold a value N. One waveform step occurs every N+1 selected ticks.
- R6: Control bit 15 (channel 0) and bit 23 (channel 1) gate the ticks. With its gate clear, a running channel freezes in its current state.
- R7: A channel that is started begins its high phase at once. The output is high for (high count) steps, then low for (low count) steps, then repeats.
- R8: A high count of zero gives a constant low output. A low count of zero with a nonzero high count gives a constant high output. Both counts zero gives low.
- R9: Clearing a run bit drives that output low from the same edge that updates the register. It also clears the prescaler and the step position, so the next start begins a fresh high phase.
- R10: A channel word written while the channel runs takes effect only after the last step of the current period.
- R11: After reset, all registers read zero and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register byte offset |
| reg_wr | input | 1 | Write strobe, captured on the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| tick_src | input | 4 | Four tick strobes to choose from |
| pwm_out | output | 2 | Channel outputs, bit i for channel i |

## Verification
A register write lands on the rising edge that samples the strobe. From that same edge on, read data shows the new value, and a cleared run bit forces its output low. A waveform step happens on the edge where the selected tick arrives and the prescaler is at its terminal count. The output shows the new step position right after that edge, so the output lags the qualifying tick by exactly one edge. The bench keeps a behavioural model that advances on each rising edge, using the inputs held stable since the previous falling edge. It compares both outputs on every falling edge. The explicit sequence checks also start sampling at the falling edge just after the write that starts them, so expected and actual values are always taken at the same point in the cycle.

// File: rtl/duo_pwm_pkg.sv
package duo_pwm_pkg;
  localparam int NCH    = 2;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;
  localparam int DIV_W  = 7;
  localparam int NSRC   = 4;
  localparam int SEL_W  = $clog2(NSRC);
  // control field positions (decoded by software and by the channel slices)
  localparam int RUN_LSB  = 0;
  localparam int SEL_LSB  = 4;
  localparam int DIV_LSB  = 8;
  localparam int GATE_LSB = 15;
  localparam int CH_STRIDE = 8;
  localparam logic [DATA_W-1:0] CTRL_MASK = 32'h00FF_FFF3;
endpackage

// File: rtl/duo_pwm_regs.sv
module duo_pwm_regs
  import duo_pwm_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] word0,
  output logic [DATA_W-1:0] word1,
  output logic [DATA_W-1:0] ctrl
);
  localparam logic [ADDR_W-1:0] OFS_W0   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_W1   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(8);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word0 <= '0;
      word1 <= '0;
      ctrl  <= '0;
    end else if (wr) begin
      if (addr == OFS_W0)   word0 <= wdata;
      if (addr == OFS_W1)   word1 <= wdata;
      if (addr == OFS_CTRL) ctrl  <= wdata & CTRL_MASK;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == OFS_W0)   rdata = word0;
    if (addr == OFS_W1)   rdata = word1;
    if (addr == OFS_CTRL) rdata = ctrl;
  end
endmodule

// File: rtl/duo_pwm_chan.sv
module duo_pwm_chan #(
  parameter int CNT_W = 16,
  parameter int DIV_W = 7,
  parameter int NSRC  = 4,
  localparam int SEL_W = $clog2(NSRC),
  localparam int POS_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             gate,
  input  logic [SEL_W-1:0] sel,
  input  logic [DIV_W-1:0] div,
  input  logic [CNT_W-1:0] word_hi,
  input  logic [CNT_W-1:0] word_lo,
  input  logic [NSRC-1:0]  tick_src,
  output logic             out,
  output logic             step,
  output logic             wrap,
  output logic [POS_W-1:0] pos,
  output logic [CNT_W-1:0] act_hi,
  output logic [CNT_W-1:0] act_lo
);
  localparam logic [POS_W-1:0] POS_ONE = POS_W'(1);
  localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);

  // true when the step at position p is the last of a period of hi+lo steps
  function automatic logic last_step(input logic [POS_W-1:0] p,
                                     input logic [CNT_W-1:0] hi,
                                     input logic [CNT_W-1:0] lo);
    logic [POS_W:0] nxt, tot;
    nxt = {1'b0, p} + {1'b0, POS_ONE};
    tot = {2'b00, hi} + {2'b00, lo};
    return nxt >= tot;
  endfunction

  // output level for a step position
  function automatic logic level_at(input logic [POS_W-1:0] p,
                                    input logic [CNT_W-1:0] hi);
    return {1'b0, hi} > p;
  endfunction

  logic [DIV_W-1:0] pre;
  logic             tick;
  logic             pre_hit;

  assign tick    = gate & tick_src[sel];
  assign pre_hit = (pre == div);
  assign step    = run & tick & pre_hit;
  assign wrap    = step & last_step(pos, act_hi, act_lo);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre    <= '0;
      pos    <= '0;
      act_hi <= '0;
      act_lo <= '0;
    end else if (!run) begin
      pre    <= '0;
      pos    <= '0;
      act_hi <= word_hi;
      act_lo <= word_lo;
    end else begin
      if (tick) pre <= pre_hit ? '0 : pre + DIV_ONE;
      if (wrap) begin
        pos    <= '0;
        act_hi <= word_hi;
        act_lo <= word_lo;
      end else if (step) begin
        pos <= pos + POS_ONE;
      end
    end
  end

  assign out = run & level_at(pos, act_hi);
endmodule

// File: rtl/duo_pwm.sv
module duo_pwm
  import duo_pwm_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [3:0]        tick_src,
  output logic [1:0]        pwm_out
);
  localparam int POS_W = CNT_W + 1;

  logic [DATA_W-1:0] word0, word1, ctrl;
  logic [NCH-1:0][DATA_W-1:0] word_v;

  // named internal events for the checker
  logic [NCH-1:0]             run_v, gate_v, step_v, wrap_v;
  logic [NCH-1:0][POS_W-1:0]  pos_v;
  logic [NCH-1:0][CNT_W-1:0]  hi_v, lo_v;

  duo_pwm_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (reg_addr),
    .wr    (reg_wr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .word0 (word0),
    .word1 (word1),
    .ctrl  (ctrl)
  );

  assign word_v[0] = word0;
  assign word_v[1] = word1;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [SEL_W-1:0] sel_f;
    logic [DIV_W-1:0] div_f;

    assign run_v[i]  = ctrl[RUN_LSB + i];
    assign gate_v[i] = ctrl[GATE_LSB + CH_STRIDE*i];
    assign sel_f     = ctrl[SEL_LSB + SEL_W*i +: SEL_W];
    assign div_f     = ctrl[DIV_LSB + CH_STRIDE*i +: DIV_W];

    duo_pwm_chan #(.CNT_W(CNT_W), .DIV_W(DIV_W), .NSRC(NSRC)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run_v[i]),
      .gate     (gate_v[i]),
      .sel      (sel_f),
      .div      (div_f),
      .word_hi  (word_v[i][DATA_W-1:CNT_W]),
      .word_lo  (word_v[i][CNT_W-1:0]),
      .tick_src (tick_src),
      .out      (pwm_out[i]),
      .step     (step_v[i]),
      .wrap     (wrap_v[i]),
      .pos      (pos_v[i]),
      .act_hi   (hi_v[i]),
      .act_lo   (lo_v[i])
    );
  end
endmodule

// File: rtl/duo_pwm_chk.sv
module duo_pwm_chk #(
  parameter int NCH   = 2,
  parameter int CNT_W = 16,
  localparam int POS_W = CNT_W + 1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NCH-1:0]             run,
  input logic [NCH-1:0]             gate,
  input logic [NCH-1:0]             step,
  input logic [NCH-1:0]             wrap,
  input logic [NCH-1:0]             out,
  input logic [NCH-1:0][POS_W-1:0]  pos,
  input logic [NCH-1:0][CNT_W-1:0]  hi,
  input logic [NCH-1:0][CNT_W-1:0]  lo
);
  for (genvar i = 0; i < NCH; i++) begin : g_a
    a_r6_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      !gate[i] |-> !step[i]);
    a_r9_off_low: assert property (@(posedge clk) disable iff (!rst_n)
      !run[i] |-> !out[i]);
    a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
      !run[i] |=> (pos[i] == '0));
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (run[i] && !wrap[i]) |=> ($stable(hi[i]) && $stable(lo[i])));
    a_r8_hi_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
      (run[i] && hi[i] == '0) |-> !out[i]);
    a_r8_lo_zero_high: assert property (@(posedge clk) disable iff (!rst_n)
      (run[i] && lo[i] == '0 && hi[i] != '0) |-> out[i]);
    a_r7_pos_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (run[i] && ({1'b0, hi[i]} + {1'b0, lo[i]}) != '0) |->
      (pos[i] < ({1'b0, hi[i]} + {1'b0, lo[i]})));
  end
endmodule

bind duo_pwm duo_pwm_chk #(.NCH(duo_pwm_pkg::NCH), .CNT_W(duo_pwm_pkg::CNT_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .run   (run_v),
  .gate  (gate_v),
  .step  (step_v),
  .wrap  (wrap_v),
  .out   (pwm_out),
  .pos   (pos_v),
  .hi    (hi_v),
  .lo    (lo_v)
);

// File: tb/tb_duo_pwm.sv
module tb_duo_pwm;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [3:0]  src = '0;
  wire  [31:0] rdata;
  wire  [1:0]  pwm;

  duo_pwm dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wr(wr),
    .reg_wdata(wdata), .reg_rdata(rdata), .tick_src(src), .pwm_out(pwm)
  );

  int    total = 0, fails = 0, cyc = 0;
  string cur_req = "R11";
  bit    cmp_en = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // tick sources: [0] every cycle, [1] never, [2] every other, [3] every third
  always @(negedge clk) begin
    cyc++;
    src <= {(cyc % 3) == 0, cyc[0], 1'b0, 1'b1};
  end

  // behavioural reference model
  logic [31:0] m_word[2];
  logic [31:0] m_ctrl;
  int m_pre[2], m_pos[2], m_hi[2], m_lo[2];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = '0;
      for (int c = 0; c < 2; c++) begin
        m_word[c] = '0; m_pre[c] = 0; m_pos[c] = 0; m_hi[c] = 0; m_lo[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        bit run, gate, tk;
        int sel, dv;
        run  = m_ctrl[c];
        gate = m_ctrl[15 + 8*c];
        sel  = (m_ctrl >> (4 + 2*c)) & 3;
        dv   = (m_ctrl >> (8 + 8*c)) & 127;
        tk   = gate && src[sel];
        if (!run) begin
          m_pre[c] = 0; m_pos[c] = 0;
          m_hi[c] = m_word[c][31:16]; m_lo[c] = m_word[c][15:0];
        end else if (tk) begin
          if (m_pre[c] == dv) begin
            m_pre[c] = 0;
            if (m_pos[c] + 1 >= m_hi[c] + m_lo[c]) begin
              m_pos[c] = 0;
              m_hi[c] = m_word[c][31:16]; m_lo[c] = m_word[c][15:0];
            end else m_pos[c]++;
          end else m_pre[c]++;
        end
      end
      if (wr) begin
        if (addr == 4'h0) m_word[0] = wdata;
        if (addr == 4'h4) m_word[1] = wdata;
        if (addr == 4'h8) m_ctrl = wdata & 32'h00FF_FFF3;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      for (int c = 0; c < 2; c++)
        chk(cur_req, {31'd0, pwm[c]}, {31'd0, (m_ctrl[c] && (m_pos[c] < m_hi[c]))});
    end
  end

  task automatic wr_reg(logic [3:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_chk(logic [3:0] a, logic [31:0] exp, string tag);
    @(negedge clk); addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic samp(int ch, bit exp, string tag);
    chk(tag, {31'd0, pwm[ch]}, {31'd0, exp});
    @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // watchdog
  always @(posedge clk) begin
    if (cyc > 50000) begin
      fails++; total++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    idle(5);
    // R11 reset state
    rd_chk(4'h0, 32'h0, "R11");
    rd_chk(4'h4, 32'h0, "R11");
    rd_chk(4'h8, 32'h0, "R11");
    chk("R11", {30'd0, pwm}, 32'h0);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    idle(2);

    // R1 / R2 register map and readback
    cur_req = "R1";
    wr_reg(4'h0, 32'h0003_0002);
    wr_reg(4'h4, 32'h1234_5678);
    rd_chk(4'h0, 32'h0003_0002, "R2");
    rd_chk(4'h4, 32'h1234_5678, "R1");
    rd_chk(4'hC, 32'h0, "R1");
    wr_reg(4'h8, 32'hFFFF_FFFF);
    rd_chk(4'h8, 32'h00FF_FFF3, "R1");
    wr_reg(4'h8, 32'h0);

    // R7 basic waveform 3 high / 2 low, no division
    cur_req = "R7";
    wr_reg(4'h8, 32'h0000_8001);
    for (int k = 0; k < 10; k++) samp(0, (k % 5) < 3, "R7");

    // R5 divide by three
    cur_req = "R5";
    wr_reg(4'h8, 32'h0);
    wr_reg(4'h8, 32'h0000_8201);
    for (int k = 0; k < 15; k++) samp(0, k < 9, "R5");
    samp(0, 1'b1, "R5");

    // R4 / R3 channel 1 on a dead source, channel 0 off
    cur_req = "R4";
    wr_reg(4'h8, 32'h0);
    wr_reg(4'h4, 32'h0001_0001);
    wr_reg(4'h8, 32'h0080_0042);
    idle(20);
    chk("R4", {31'd0, pwm[1]}, 32'd1);
    chk("R3", {31'd0, pwm[0]}, 32'd0);
    wr_reg(4'h8, 32'h0080_00C2);
    idle(30);
    wr_reg(4'h8, 32'h0080_0082);
    idle(30);
    cur_req = "R3";
    wr_reg(4'h8, 32'h0080_8083);
    idle(40);

    // R6 gate closed freezes the channel
    cur_req = "R6";
    wr_reg(4'h8, 32'h0);
    wr_reg(4'h0, 32'h0002_0002);
    wr_reg(4'h8, 32'h0000_0001);
    for (int k = 0; k < 20; k++) samp(0, 1'b1, "R6");
    wr_reg(4'h8, 32'h0000_8001);
    idle(20);

    // R8 degenerate counts
    cur_req = "R8";
    wr_reg(4'h8, 32'h0);
    wr_reg(4'h0, 32'h0000_0004);
    wr_reg(4'h8, 32'h0000_8001);
    for (int k = 0; k < 12; k++) samp(0, 1'b0, "R8");
    wr_reg(4'h8, 32'h0);
    wr_reg(4'h0, 32'h0005_0000);
    wr_reg(4'h8, 32'h0000_8001);
    for (int k = 0; k < 12; k++) samp(0, 1'b1, "R8");
    wr_reg(4'h8, 32'h0);
    wr_reg(4'h0, 32'h0000_0000);
    wr_reg(4'h8, 32'h0000_8001);
    for (int k = 0; k < 12; k++) samp(0, 1'b0, "R8");

    // R9 disable mid-period and restart
    cur_req = "R9";
    wr_reg(4'h8, 32'h0);
    wr_reg(4'h0, 32'h0004_0004);
    wr_reg(4'h8, 32'h0000_8001);
    idle(5);
    chk("R9", {31'd0, pwm[0]}, 32'd0);
    wr_reg(4'h8, 32'h0);
    chk("R9", {31'd0, pwm[0]}, 32'd0);
    wr_reg(4'h8, 32'h0000_8001);
    for (int k = 0; k < 8; k++) samp(0, k < 4, "R9");

    // R10 rewrite while running
    cur_req = "R10";
    wr_reg(4'h8, 32'h0);
    wr_reg(4'h0, 32'h0003_0002);
    wr_reg(4'h8, 32'h0000_8001);
    wr_reg(4'h0, 32'h0001_0001);
    samp(0, 1'b1, "R10");
    samp(0, 1'b0, "R10");
    samp(0, 1'b0, "R10");
    samp(0, 1'b1, "R10");
    samp(0, 1'b0, "R10");
    samp(0, 1'b1, "R10");
    samp(0, 1'b0, "R10");
    rd_chk(4'h0, 32'h0001_0001, "R10");
    idle(10);

    cmp_en = 1'b0;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule